// File: doc/BRIEF.md
# Power-Management Configuration Window Decoder

This block is the configuration-space front end of a south-bridge power-management function. It holds a byte-addressable configuration file that is written and read one dword at a time, with byte enables. From two base dwords and two enable bytes in that file it derives two relocatable 64-byte I/O windows: one for the power-management registers and one for the SMBus host. Each I/O cycle is matched against both windows. A hit produces a one-cycle strobe together with the offset inside the window.

A fixed general-purpose-event window at a parameterised I/O address accepts accesses of 1 to 4 bytes. The block replays each such access as a train of single-byte strobes, lowest byte first.

An APM command port controls ACPI mode. The enable command sets the SCI-enable status bit and the disable command clears it. Every write to the port can also raise a one-cycle SMI pulse, gated by a bit in the configuration file. The timer, the event registers and the SMBus controller are not part of this block. They attach to the hit strobes.

Top module: `pmcfg_decoder`

## Requirements
- R1: After reset, the configuration file reads as follows. Dword 0x10 (bytes 0x40-0x43) reads 0x00000001. Dword 0x16 reads 0x02000000, which is byte 0x5b = 0x02 when SMM is not supported. Dword 0x34 reads 0x00090000, which is byte 0xd2 = 0x09. Dword 0x24 reads SMB_BASE_RST with bit 0 set. All other bytes read 0.
- R2: A configuration write updates only the bytes whose enable is set (bit n of cfg_be_i selects byte lane n, bits 8n+7:8n). Reads return the stored dword at cfg_addr_i, with the lowest byte address in bits 7:0.
- R3: Bit 0 of byte 0x40 and bit 0 of byte 0x90 ignore writes and always read 1.
- R4: The PM window is enabled by bit 0 of byte 0x80 and is disabled after reset. An I/O cycle whose address bits 15:6 equal bits 15:6 of bytes 0x41:0x40 gives pm_hit_o = 1 and pm_off_o = address bits 5:0 in the next cycle. Any other cycle gives no hit.
- R5: Bytes 0x42, 0x43, 0x92 and 0x93 and the low six bits of each base have no effect on decoding.
- R6: The SMBus window takes its base from bytes 0x91:0x90 and its enable from bit 0 of byte 0xd2. It decodes from reset at SMB_BASE_RST and gives smb_hit_o and smb_off_o under the same rule as R4.
- R7: A write to a base or enable byte moves or gates its window starting with I/O cycles presented in the cycle after the write.
- R8: An I/O cycle inside [GPE_BASE, GPE_BASE+GPE_LEN) with io_len_i = N-1 is accepted when the splitter is idle. Starting the next cycle, gpe_busy_o is high for N cycles. In cycle k (k = 0 to N-1), gpe_lane_o = k and gpe_off_o = start offset + k. gpe_stb_o is high only when that offset is below GPE_LEN.
- R9: An event-window I/O cycle presented while gpe_busy_o is high is ignored.
- R10: An APM write of 0xf1 sets sci_en_o and a write of 0xf0 clears it, each visible the next cycle. Any other value leaves sci_en_o unchanged.
- R11: Each APM write gives smi_o = 1 for exactly the next cycle when bit 1 of byte 0x5b is set, and no pulse when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration dword address |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Dword stored at cfg_addr_i |
| io_valid_i | input | 1 | I/O cycle present |
| io_addr_i | input | 16 | I/O address |
| io_len_i | input | 2 | Access length minus one |
| pm_hit_o | output | 1 | PM window hit, one cycle after the I/O cycle |
| pm_off_o | output | 6 | Offset inside the PM window |
| smb_hit_o | output | 1 | SMBus window hit |
| smb_off_o | output | 6 | Offset inside the SMBus window |
| gpe_stb_o | output | 1 | Event-window byte strobe |
| gpe_off_o | output | 2 | Byte offset inside the event window |
| gpe_lane_o | output | 2 | Byte lane of the original access |
| gpe_busy_o | output | 1 | Splitter is replaying an access |
| apm_we_i | input | 1 | APM command write |
| apm_data_i | input | 8 | APM command byte |
| sci_en_o | output | 1 | SCI-enable status |
| smi_o | output | 1 | SMI pulse |

## Verification
Several properties are checked on every cycle. Read-only bit 0 of the PM base always reads as 1. Any window hit has an I/O cycle in the previous cycle, and its offset matches that cycle's low address bits. No event strobe appears outside a busy period. sci_en_o moves only on the two APM commands. Every SMI pulse follows an APM write.

Other behaviour only the directed scenarios can show, because it depends on stored history. This covers the reset contents, partial byte-enable merges, relocation and disabling of each window, and the upper base bytes being ignored. It also covers the order and clipping of the event-byte trains, the rejection of an event access that arrives during a train, and the SMI gate being removed through the configuration file.

// File: rtl/pmcfg_pkg.sv
package pmcfg_pkg;
  localparam int unsigned IO_AW    = 16;
  localparam int unsigned WIN_LOG2 = 6;
  localparam int unsigned BASE_W   = IO_AW - WIN_LOG2;
  localparam int unsigned N_WIN    = 2;

  // byte offsets whose position other logic decodes
  localparam int unsigned PM_BASE_OFS  = 'h40;
  localparam int unsigned PM_EN_OFS    = 'h80;
  localparam int unsigned SMM_CTL_OFS  = 'h5b;
  localparam int unsigned SMB_BASE_OFS = 'h90;
  localparam int unsigned SMB_EN_OFS   = 'hd2;

  localparam logic [7:0] APM_ACPI_ON  = 8'hf1;
  localparam logic [7:0] APM_ACPI_OFF = 8'hf0;

  typedef struct packed {
    logic              en;
    logic [BASE_W-1:0] base;
  } win_cfg_t;
endpackage

// File: rtl/pmcfg_regfile.sv
module pmcfg_regfile
  import pmcfg_pkg::*;
#(
  parameter int unsigned CFG_BYTES     = 256,
  parameter bit          SMM_SUPPORTED = 1'b0,
  parameter logic [15:0] SMB_BASE_RST  = 16'h1100
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [$clog2(CFG_BYTES)-3:0]    dw_i,
  input  logic [3:0]                      be_i,
  input  logic [31:0]                     wdata_i,
  output logic [31:0]                     rdata_o,
  output win_cfg_t                        pm_win_o,
  output win_cfg_t                        smb_win_o,
  output logic                            smi_gate_o
);
  localparam int unsigned IDX_W = $clog2(CFG_BYTES);
  localparam int unsigned DW_W  = IDX_W - 2;
  localparam logic [DW_W-1:0] PM_BASE_DW  = DW_W'(PM_BASE_OFS >> 2);
  localparam logic [DW_W-1:0] PM_EN_DW    = DW_W'(PM_EN_OFS >> 2);
  localparam logic [DW_W-1:0] SMB_BASE_DW = DW_W'(SMB_BASE_OFS >> 2);
  localparam logic [DW_W-1:0] SMB_EN_DW   = DW_W'(SMB_EN_OFS >> 2);
  localparam int unsigned PM_EN_LANE  = PM_EN_OFS % 4;
  localparam int unsigned SMB_EN_LANE = SMB_EN_OFS % 4;

  function automatic logic [7:0] rst_val(int unsigned i);
    if (i == PM_BASE_OFS)          return 8'h01;
    if (i == SMM_CTL_OFS)          return SMM_SUPPORTED ? 8'h00 : 8'h02;
    if (i == SMB_BASE_OFS)         return SMB_BASE_RST[7:0] | 8'h01;
    if (i == SMB_BASE_OFS + 1)     return SMB_BASE_RST[15:8];
    if (i == SMB_EN_OFS)           return 8'h09;
    return 8'h00;
  endfunction

  // I/O-space indicator bits are hardwired
  function automatic logic [7:0] ro_mask(int unsigned i);
    return (i == PM_BASE_OFS || i == SMB_BASE_OFS) ? 8'h01 : 8'h00;
  endfunction

  logic [7:0] mem_q [CFG_BYTES];
  logic [7:0] old_b [4];
  logic [7:0] mrg_b [4];
  win_cfg_t   pm_q, smb_q;

  always_comb begin
    for (int j = 0; j < 4; j++) begin
      logic [IDX_W-1:0] idx;
      logic [7:0]       ro;
      idx      = {dw_i, 2'(j)};
      ro       = ro_mask(int'(idx));
      old_b[j] = mem_q[idx];
      mrg_b[j] = be_i[j] ? ((wdata_i[8*j +: 8] & ~ro) | (old_b[j] & ro)) : old_b[j];
    end
  end

  assign rdata_o = {old_b[3], old_b[2], old_b[1], old_b[0]};

  logic pm_base_touch, pm_en_touch, smb_base_touch, smb_en_touch;
  assign pm_base_touch  = we_i && dw_i == PM_BASE_DW  && |be_i;
  assign pm_en_touch    = we_i && dw_i == PM_EN_DW    && be_i[PM_EN_LANE];
  assign smb_base_touch = we_i && dw_i == SMB_BASE_DW && |be_i;
  assign smb_en_touch   = we_i && dw_i == SMB_EN_DW   && be_i[SMB_EN_LANE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CFG_BYTES; i++) mem_q[i] <= rst_val(i);
      pm_q.en    <= 1'b0;
      pm_q.base  <= '0;
      smb_q.en   <= 1'b1;
      smb_q.base <= SMB_BASE_RST[15:WIN_LOG2];
    end else if (we_i) begin
      for (int j = 0; j < 4; j++) mem_q[{dw_i, 2'(j)}] <= mrg_b[j];
      if (pm_base_touch)  pm_q.base  <= {mrg_b[1], mrg_b[0][7:WIN_LOG2]};
      if (pm_en_touch)    pm_q.en    <= mrg_b[PM_EN_LANE][0];
      if (smb_base_touch) smb_q.base <= {mrg_b[1], mrg_b[0][7:WIN_LOG2]};
      if (smb_en_touch)   smb_q.en   <= mrg_b[SMB_EN_LANE][0];
    end
  end

  assign pm_win_o   = pm_q;
  assign smb_win_o  = smb_q;
  assign smi_gate_o = mem_q[SMM_CTL_OFS][1];
endmodule

// File: rtl/pmcfg_win_dec.sv
module pmcfg_win_dec
  import pmcfg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [IO_AW-1:0]    addr_i,
  input  win_cfg_t            cfg_i,
  output logic                hit_o,
  output logic [WIN_LOG2-1:0] off_o
);
  logic match;
  assign match = valid_i && cfg_i.en && (addr_i[IO_AW-1:WIN_LOG2] == cfg_i.base);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o <= 1'b0;
      off_o <= '0;
    end else begin
      hit_o <= match;
      if (match) off_o <= addr_i[WIN_LOG2-1:0];
    end
  end
endmodule

// File: rtl/pmcfg_gpe_split.sv
module pmcfg_gpe_split
  import pmcfg_pkg::*;
#(
  parameter logic [15:0] GPE_BASE = 16'hafe0,
  parameter int unsigned GPE_LEN  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [IO_AW-1:0]           addr_i,
  input  logic [1:0]                 len_i,
  output logic                       stb_o,
  output logic [$clog2(GPE_LEN)-1:0] off_o,
  output logic [1:0]                 lane_o,
  output logic                       busy_o
);
  localparam int unsigned GPE_AW = $clog2(GPE_LEN);
  localparam int unsigned OFS_W  = $clog2(GPE_LEN + 4);
  localparam logic [IO_AW:0] LO  = {1'b0, GPE_BASE};
  localparam logic [IO_AW:0] HI  = LO + (IO_AW+1)'(GPE_LEN);

  logic             act_q;
  logic [1:0]       rem_q, lane_q;
  logic [OFS_W-1:0] ofs_q;
  logic             in_win, accept;
  logic [IO_AW-1:0] rel;

  assign in_win = ({1'b0, addr_i} >= LO) && ({1'b0, addr_i} < HI);
  assign accept = valid_i && in_win && !act_q;
  assign rel    = addr_i - GPE_BASE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      rem_q  <= '0;
      lane_q <= '0;
      ofs_q  <= '0;
    end else if (accept) begin
      act_q  <= 1'b1;
      rem_q  <= len_i;
      lane_q <= '0;
      ofs_q  <= OFS_W'(rel);
    end else if (act_q) begin
      if (rem_q == '0) act_q <= 1'b0;
      rem_q  <= rem_q - 2'd1;
      lane_q <= lane_q + 2'd1;
      ofs_q  <= ofs_q + OFS_W'(1);
    end
  end

  // bytes beyond the window are dropped
  assign stb_o  = act_q && (ofs_q < OFS_W'(GPE_LEN));
  assign off_o  = ofs_q[GPE_AW-1:0];
  assign lane_o = lane_q;
  assign busy_o = act_q;
endmodule

// File: rtl/pmcfg_apm.sv
module pmcfg_apm
  import pmcfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] data_i,
  input  logic       smi_gate_i,
  output logic       sci_en_o,
  output logic       smi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sci_en_o <= 1'b0;
      smi_o    <= 1'b0;
    end else begin
      smi_o <= we_i && smi_gate_i;
      if (we_i && data_i == APM_ACPI_ON)  sci_en_o <= 1'b1;
      if (we_i && data_i == APM_ACPI_OFF) sci_en_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pmcfg_decoder.sv
module pmcfg_decoder
  import pmcfg_pkg::*;
#(
  parameter int unsigned CFG_BYTES     = 256,
  parameter bit          SMM_SUPPORTED = 1'b0,
  parameter logic [15:0] SMB_BASE_RST  = 16'h1100,
  parameter logic [15:0] GPE_BASE      = 16'hafe0,
  parameter int unsigned GPE_LEN       = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [5:0]  cfg_addr_i,
  input  logic [3:0]  cfg_be_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        io_valid_i,
  input  logic [15:0] io_addr_i,
  input  logic [1:0]  io_len_i,
  output logic        pm_hit_o,
  output logic [5:0]  pm_off_o,
  output logic        smb_hit_o,
  output logic [5:0]  smb_off_o,
  output logic        gpe_stb_o,
  output logic [1:0]  gpe_off_o,
  output logic [1:0]  gpe_lane_o,
  output logic        gpe_busy_o,
  input  logic        apm_we_i,
  input  logic [7:0]  apm_data_i,
  output logic        sci_en_o,
  output logic        smi_o
);
  localparam int unsigned GPE_AW = $clog2(GPE_LEN);

  win_cfg_t            win_cfg [N_WIN];
  logic                win_hit [N_WIN];
  logic [WIN_LOG2-1:0] win_off [N_WIN];
  logic                smi_gate;

  pmcfg_regfile #(
    .CFG_BYTES    (CFG_BYTES),
    .SMM_SUPPORTED(SMM_SUPPORTED),
    .SMB_BASE_RST (SMB_BASE_RST)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .dw_i      (cfg_addr_i),
    .be_i      (cfg_be_i),
    .wdata_i   (cfg_wdata_i),
    .rdata_o   (cfg_rdata_o),
    .pm_win_o  (win_cfg[0]),
    .smb_win_o (win_cfg[1]),
    .smi_gate_o(smi_gate)
  );

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    pmcfg_win_dec u_dec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(io_valid_i),
      .addr_i (io_addr_i),
      .cfg_i  (win_cfg[w]),
      .hit_o  (win_hit[w]),
      .off_o  (win_off[w])
    );
  end

  assign pm_hit_o  = win_hit[0];
  assign pm_off_o  = win_off[0];
  assign smb_hit_o = win_hit[1];
  assign smb_off_o = win_off[1];

  pmcfg_gpe_split #(
    .GPE_BASE(GPE_BASE),
    .GPE_LEN (GPE_LEN)
  ) u_gpe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(io_valid_i),
    .addr_i (io_addr_i),
    .len_i  (io_len_i),
    .stb_o  (gpe_stb_o),
    .off_o  (gpe_off_o),
    .lane_o (gpe_lane_o),
    .busy_o (gpe_busy_o)
  );

  pmcfg_apm u_apm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (apm_we_i),
    .data_i    (apm_data_i),
    .smi_gate_i(smi_gate),
    .sci_en_o  (sci_en_o),
    .smi_o     (smi_o)
  );
endmodule

// File: rtl/pmcfg_decoder_chk.sv
module pmcfg_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [5:0]  cfg_addr_i,
  input logic [3:0]  cfg_be_i,
  input logic [31:0] cfg_wdata_i,
  input logic [31:0] cfg_rdata_o,
  input logic        io_valid_i,
  input logic [15:0] io_addr_i,
  input logic [1:0]  io_len_i,
  input logic        pm_hit_o,
  input logic [5:0]  pm_off_o,
  input logic        smb_hit_o,
  input logic [5:0]  smb_off_o,
  input logic        gpe_stb_o,
  input logic [1:0]  gpe_off_o,
  input logic [1:0]  gpe_lane_o,
  input logic        gpe_busy_o,
  input logic        apm_we_i,
  input logic [7:0]  apm_data_i,
  input logic        sci_en_o,
  input logic        smi_o
);
  a_r3_pm_io_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_addr_i == 6'h10 |-> cfg_rdata_o[0]);

  a_r4_pm_hit_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_hit_o |-> $past(io_valid_i));

  a_r4_pm_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_hit_o |-> pm_off_o == $past(io_addr_i[5:0]));

  a_r6_smb_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smb_hit_o |-> smb_off_o == $past(io_addr_i[5:0]) && $past(io_valid_i));

  a_r8_stb_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpe_stb_o |-> gpe_busy_o);

  a_r10_sci_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apm_we_i && apm_data_i == 8'hf1 |=> sci_en_o);

  a_r10_sci_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apm_we_i && apm_data_i == 8'hf0 |=> !sci_en_o);

  a_r10_sci_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(apm_we_i && (apm_data_i == 8'hf0 || apm_data_i == 8'hf1)) |=> $stable(sci_en_o));

  a_r11_smi_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> $past(apm_we_i));
endmodule

bind pmcfg_decoder pmcfg_decoder_chk u_chk (.*);

// File: tb/pmcfg_decoder_bench.sv
module pmcfg_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [3:0]  cfg_be_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        io_valid_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic [1:0]  io_len_i = '0;
  logic        pm_hit_o, smb_hit_o, gpe_stb_o, gpe_busy_o;
  logic [5:0]  pm_off_o, smb_off_o;
  logic [1:0]  gpe_off_o, gpe_lane_o;
  logic        apm_we_i = 1'b0;
  logic [7:0]  apm_data_i = '0;
  logic        sci_en_o, smi_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  pmcfg_decoder u_pmcfg_decoder (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = dw; cfg_be_i = be; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_be_i = '0;
  endtask

  task automatic cfg_rd(string tag, logic [5:0] dw, logic [31:0] exp);
    cfg_addr_i = dw;
    #1;
    chk(tag, cfg_rdata_o, exp);
  endtask

  task automatic io_chk(string tag, logic [15:0] a, logic pm, logic [5:0] pmo,
                        logic smb, logic [5:0] smbo);
    @(negedge clk_i);
    io_valid_i = 1'b1; io_addr_i = a; io_len_i = 2'd0;
    @(negedge clk_i);
    io_valid_i = 1'b0;
    chk({tag, " pm_hit"}, 32'(pm_hit_o), 32'(pm));
    if (pm) chk({tag, " pm_off"}, 32'(pm_off_o), 32'(pmo));
    chk({tag, " smb_hit"}, 32'(smb_hit_o), 32'(smb));
    if (smb) chk({tag, " smb_off"}, 32'(smb_off_o), 32'(smbo));
  endtask

  task automatic gpe_run(string tag, logic [15:0] a, logic [1:0] len, int first, int nstb);
    int seen = 0;
    @(negedge clk_i);
    io_valid_i = 1'b1; io_addr_i = a; io_len_i = len;
    @(negedge clk_i);
    io_valid_i = 1'b0;
    for (int k = 0; k <= int'(len); k++) begin
      chk({tag, " busy"}, 32'(gpe_busy_o), 32'd1);
      chk({tag, " lane"}, 32'(gpe_lane_o), 32'(k));
      if (first + k < 4) chk({tag, " off"}, 32'(gpe_off_o), 32'(first + k));
      if (gpe_stb_o) seen++;
      @(negedge clk_i);
    end
    chk({tag, " idle"}, 32'(gpe_busy_o), 32'd0);
    chk({tag, " strobes"}, 32'(seen), 32'(nstb));
  endtask

  task automatic gpe_busy_ignore();
    int seen = 0;
    @(negedge clk_i);
    io_valid_i = 1'b1; io_addr_i = 16'hafe0; io_len_i = 2'd3;
    @(negedge clk_i);
    io_addr_i = 16'hafe3; io_len_i = 2'd0;    // arrives during the train
    chk("R9 first off", 32'(gpe_off_o), 32'd0);
    if (gpe_stb_o) seen++;
    @(negedge clk_i);
    io_valid_i = 1'b0;
    for (int k = 1; k < 4; k++) begin
      chk("R9 off seq", 32'(gpe_off_o), 32'(k));
      if (gpe_stb_o) seen++;
      @(negedge clk_i);
    end
    chk("R9 no extra train", 32'(gpe_busy_o), 32'd0);
    chk("R9 strobe count", 32'(seen), 32'd4);
  endtask

  task automatic apm_chk(string tag, logic [7:0] d, logic exp_sci, logic exp_smi);
    @(negedge clk_i);
    apm_we_i = 1'b1; apm_data_i = d;
    @(negedge clk_i);
    apm_we_i = 1'b0;
    chk({tag, " sci"}, 32'(sci_en_o), 32'(exp_sci));
    chk({tag, " smi"}, 32'(smi_o), 32'(exp_smi));
    @(negedge clk_i);
    chk({tag, " smi single"}, 32'(smi_o), 32'd0);
  endtask

  task automatic t_reset();
    cfg_rd("R1 pm base", 6'h10, 32'h0000_0001);
    cfg_rd("R1 smm ctl", 6'h16, 32'h0200_0000);
    cfg_rd("R1 smb en", 6'h34, 32'h0009_0000);
    cfg_rd("R1 smb base", 6'h24, 32'h0000_1101);
    cfg_rd("R1 pm en", 6'h20, 32'h0000_0000);
    chk("R10 sci after reset", 32'(sci_en_o), 32'd0);
    chk("R11 smi after reset", 32'(smi_o), 32'd0);
  endtask

  task automatic t_pm_window();
    io_chk("R4 disabled at reset", 16'h0005, 0, 0, 0, 0);
    cfg_wr(6'h10, 4'hf, 32'habcd_2000);
    cfg_rd("R3 ro bit kept", 6'h10, 32'habcd_2001);
    io_chk("R4 still disabled", 16'h2005, 0, 0, 0, 0);
    cfg_wr(6'h20, 4'h1, 32'h0000_0001);
    io_chk("R7 R4 enabled hit", 16'h2005, 1, 6'd5, 0, 0);
    io_chk("R4 R5 top of window", 16'h203f, 1, 6'd63, 0, 0);
    io_chk("R4 above window", 16'h2040, 0, 0, 0, 0);
    io_chk("R4 below window", 16'h1fff, 0, 0, 0, 0);
    cfg_wr(6'h10, 4'h2, 32'h0000_3000);
    cfg_rd("R2 partial write", 6'h10, 32'habcd_3001);
    io_chk("R7 relocated", 16'h3010, 1, 6'h10, 0, 0);
    io_chk("R7 old base gone", 16'h2005, 0, 0, 0, 0);
    cfg_wr(6'h10, 4'hc, 32'h1234_0000);
    io_chk("R5 upper bytes ignored", 16'h3021, 1, 6'h21, 0, 0);
  endtask

  task automatic t_smb_window();
    io_chk("R6 reset window", 16'h1105, 0, 0, 1, 6'd5);
    cfg_wr(6'h34, 4'h4, 32'h0000_0000);
    cfg_rd("R2 enable byte cleared", 6'h34, 32'h0000_0000);
    io_chk("R6 disabled", 16'h1105, 0, 0, 0, 0);
    cfg_wr(6'h24, 4'h3, 32'hffff_403e);
    cfg_rd("R3 R2 smb base", 6'h24, 32'h0000_403f);
    cfg_wr(6'h34, 4'h4, 32'h0001_0000);
    io_chk("R6 R5 old base gone", 16'h1105, 0, 0, 0, 0);
    io_chk("R6 R7 new base", 16'h4007, 0, 0, 1, 6'd7);
  endtask

  task automatic t_apm();
    apm_chk("R10 R11 enable", 8'hf1, 1, 1);
    apm_chk("R10 R11 other value", 8'h55, 1, 1);
    apm_chk("R10 disable", 8'hf0, 0, 1);
    apm_chk("R10 other keeps clear", 8'h00, 0, 1);
    cfg_wr(6'h16, 4'h8, 32'h0000_0000);
    apm_chk("R11 gate removed", 8'hf1, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_pm_window();
    t_smb_window();
    gpe_run("R8 four bytes", 16'hafe0, 2'd3, 0, 4);
    gpe_run("R8 two bytes", 16'hafe2, 2'd1, 2, 2);
    gpe_run("R8 clipped", 16'hafe2, 2'd3, 2, 2);
    gpe_run("R8 single", 16'hafe1, 2'd0, 1, 1);
    gpe_busy_ignore();
    t_apm();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule